// File: doc/BRIEF.md
# Byte-Lane Word Memory Access Unit

This unit connects a processor's load/store path to a data memory that is 16 bits wide. The memory is built as two parallel 8-bit lanes. Both lanes share one word address decoder, and each lane has its own write enable. A request carries a byte address, a size flag (byte or word), a read/write flag and write data. The unit produces the word address, the per-lane write enables and the replicated write data. It also returns read data aligned to the low byte for byte reads, and it raises a one-cycle address-fault pulse when a word access names an odd address. A faulting access is not split into two accesses, and it never reaches the memory.

A second path, which needs no clock, handles write-back of results to registers. A byte-sized result replaces only the low byte of the destination register. Its zero, negative and carry flags are taken from the low byte of the result. A word-sized result replaces the whole register and takes its flags from the full 16 bits. The memory array, the trap handler and the arithmetic itself lie outside the block.

Top module: `lane_access_unit`

## Requirements
- R1: For every request, the word address output equals address bits 15:1. The memory read strobe is high only for a read request that does not fault, and it is high in the same cycle as that request.
- R2: A byte read returns its result one cycle after the request, with the valid flag high. Address bit 0 equal to 0 selects memory bits 7:0 and address bit 0 equal to 1 selects bits 15:8. The selected byte appears on result bits 7:0 and result bits 15:8 are zero.
- R3: A byte write raises exactly one lane enable: bit 0 for an even address, bit 1 for an odd address. The write data bus carries write-data bits 7:0 on both lanes, so the other lane keeps its stored byte.
- R4: A word access at an even address raises both lane enables on a write. On a read it returns the full memory word one cycle later. Address bit 0 plays no part in the word address.
- R5: A word read or write at an odd address raises no lane enable and no read strobe. The fault output is high for exactly the one cycle after the request, and no read result is flagged valid.
- R6: A byte access at an odd address never raises the fault output.
- R7: On write-back, a byte-sized result replaces bits 7:0 of the old register value and keeps its bits 15:8. A word-sized result replaces all 16 bits.
- R8: For a byte-sized result, zero is set when result bits 7:0 are all zero, negative equals bit 7 and carry equals bit 8.
- R9: For a word-sized result, zero is set when result bits 15:0 are all zero, negative equals bit 15 and carry equals bit 16.
- R10: While reset is held and just after it, the read result, its valid flag and the fault output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte size, 0 = word size |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (low byte used for byte writes) |
| mem_addr | output | 15 | Word address to memory |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 2 | Lane write enables, bit 0 = low lane |
| mem_wdata | output | 16 | Data to memory lanes |
| mem_rdata | input | 16 | Word read from memory (same cycle) |
| rd_data | output | 16 | Aligned read result |
| rd_valid | output | 1 | Read result valid |
| fault | output | 1 | Misaligned word access pulse |
| wb_byte | input | 1 | Write-back size, 1 = byte |
| wb_old | input | 16 | Current destination register value |
| wb_result | input | 17 | Arithmetic result including carry bit 16 |
| wb_value | output | 16 | Merged value for the destination |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |

## Verification
The case that is hardest to reach from the ports is a misaligned word write that aims at a location that already holds data. Watching the enables alone cannot show that the stored word survived. The bench therefore first fills word 4 through one word write and one byte write. It then tries a word write at address 5 with all ones and checks that both enables stay low while the fault pulses once. Finally it reads word 4 back and expects the earlier value. Odd byte accesses to the same word are run next to these, to show that the fault depends on size as well as on address parity.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int LANE_W = 8;
  localparam int NLANES = 2;
  localparam int WORD_W = LANE_W * NLANES;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
  } flags_t;

  // Choose one lane of a word and zero-extend it
  function automatic logic [WORD_W-1:0] pick_lane(input logic [WORD_W-1:0] w,
                                                  input logic hi);
    logic [LANE_W-1:0] b;
    b = hi ? w[WORD_W-1:LANE_W] : w[LANE_W-1:0];
    return {{(WORD_W-LANE_W){1'b0}}, b};
  endfunction

  // Byte-size results only replace the low lane
  function automatic logic [WORD_W-1:0] merge_low(input logic [WORD_W-1:0] old_v,
                                                  input logic [WORD_W-1:0] new_v,
                                                  input logic is_byte);
    return is_byte ? {old_v[WORD_W-1:LANE_W], new_v[LANE_W-1:0]} : new_v;
  endfunction

  function automatic flags_t calc_flags(input logic [WORD_W:0] r,
                                        input logic is_byte);
    flags_t f;
    if (is_byte) begin
      f.z = (r[LANE_W-1:0] == '0);
      f.n = r[LANE_W-1];
      f.c = r[LANE_W];
    end else begin
      f.z = (r[WORD_W-1:0] == '0);
      f.n = r[WORD_W-1];
      f.c = r[WORD_W];
    end
    return f;
  endfunction
endpackage

// File: rtl/lane_addr_dec.sv
module lane_addr_dec
  import lane_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              valid,
  input  logic              write,
  input  logic              is_byte,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-2:0] word_addr,
  output logic [NLANES-1:0] lane_we,
  output logic              rd_en,
  output logic              misalign
);
  logic [NLANES-1:0] lane_hit;

  assign word_addr = addr[ADDR_W-1:1];
  assign misalign  = valid && !is_byte && addr[0];
  assign rd_en     = valid && !write && !misalign;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    assign lane_hit[i] = is_byte ? (addr[0] == i[0]) : 1'b1;
    assign lane_we[i]  = valid && write && !misalign && lane_hit[i];
  end
endmodule

// File: rtl/lane_wb_flags.sv
module lane_wb_flags
  import lane_pkg::*;
(
  input  logic              is_byte,
  input  logic [WORD_W-1:0] old_v,
  input  logic [WORD_W:0]   result,
  output logic [WORD_W-1:0] merged,
  output flags_t            flags
);
  assign merged = merge_low(old_v, result[WORD_W-1:0], is_byte);
  assign flags  = calc_flags(result, is_byte);
endmodule

// File: rtl/lane_access_unit.sv
module lane_access_unit
  import lane_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic [ADDR_W-2:0] mem_addr,
  output logic              mem_re,
  output logic [1:0]        mem_we,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic [15:0]       rd_data,
  output logic              rd_valid,
  output logic              fault,
  input  logic              wb_byte,
  input  logic [15:0]       wb_old,
  input  logic [16:0]       wb_result,
  output logic [15:0]       wb_value,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_c
);
  logic              misalign_w;
  logic              rd_en_w;
  logic [WORD_W-1:0] aligned_w;
  flags_t            flags_w;

  lane_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .valid    (req_valid),
    .write    (req_write),
    .is_byte  (req_byte),
    .addr     (req_addr),
    .word_addr(mem_addr),
    .lane_we  (mem_we),
    .rd_en    (rd_en_w),
    .misalign (misalign_w)
  );

  assign mem_re    = rd_en_w;
  assign mem_wdata = req_byte ? {2{req_wdata[LANE_W-1:0]}} : req_wdata;
  assign aligned_w = req_byte ? pick_lane(mem_rdata, req_addr[0]) : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      fault    <= 1'b0;
    end else begin
      rd_valid <= rd_en_w;
      fault    <= misalign_w;
      if (rd_en_w) rd_data <= aligned_w;
    end
  end

  lane_wb_flags u_wb (
    .is_byte(wb_byte),
    .old_v  (wb_old),
    .result (wb_result),
    .merged (wb_value),
    .flags  (flags_w)
  );

  assign flag_z = flags_w.z;
  assign flag_n = flags_w.n;
  assign flag_c = flags_w.c;
endmodule

// File: rtl/lane_access_chk.sv
module lane_access_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_byte,
  input logic [15:0] req_addr,
  input logic [1:0]  mem_we,
  input logic        mem_re,
  input logic [15:0] rd_data,
  input logic        rd_valid,
  input logic        fault,
  input logic        misalign_w,
  input logic        wb_byte,
  input logic [15:0] wb_old,
  input logic [15:0] wb_value
);
  // R3
  byte_write_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_byte) |-> ($countones(mem_we) == 1 && mem_we[req_addr[0]]));
  // R5
  misalign_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_w |-> (mem_we == 2'b00 && !mem_re));
  // R5
  fault_follows_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_w |=> (fault && !rd_valid));
  // R5
  fault_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(req_valid && !req_byte && req_addr[0]));
  // R6
  odd_byte_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_byte) |=> !fault);
  // R2
  byte_read_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_byte) |=> (rd_valid && rd_data[15:8] == 8'h00));
  // R7
  merge_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_byte |-> (wb_value[15:8] == wb_old[15:8]));
endmodule

bind lane_access_unit lane_access_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_byte  (req_byte),
  .req_addr  (req_addr),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .fault     (fault),
  .misalign_w(misalign_w),
  .wb_byte   (wb_byte),
  .wb_old    (wb_old),
  .wb_value  (wb_value)
);

// File: tb/test_lane_access_unit.sv
module test_lane_access_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [14:0] mem_addr;
  logic        mem_re;
  logic [1:0]  mem_we;
  logic [15:0] mem_wdata, mem_rdata, rd_data;
  logic        rd_valid, fault;
  logic        wb_byte = 1'b0;
  logic [15:0] wb_old = '0;
  logic [16:0] wb_result = '0;
  logic [15:0] wb_value;
  logic        flag_z, flag_n, flag_c;

  int checks = 0;
  int fails  = 0;
  logic [15:0] ram [0:15];

  always #10 clk = ~clk;

  lane_access_unit i_lane_access_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rd_data(rd_data), .rd_valid(rd_valid), .fault(fault),
    .wb_byte(wb_byte), .wb_old(wb_old), .wb_result(wb_result), .wb_value(wb_value),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
  );

  assign mem_rdata = ram[mem_addr[3:0]];
  always @(posedge clk) begin
    if (mem_we[0]) ram[mem_addr[3:0]][7:0]  <= mem_wdata[7:0];
    if (mem_we[1]) ram[mem_addr[3:0]][15:8] <= mem_wdata[15:8];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit wr, input bit byt, input logic [15:0] a,
                       input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_byte = byt; req_addr = a; req_wdata = d;
    #1;
  endtask

  task automatic idle_after_edge();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0;
  endtask

  task automatic t_reset();
    check(rd_data == 16'h0 && !rd_valid && !fault, "R10",
          {rd_data, 14'h0, rd_valid, fault}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 16'h0 && !rd_valid && !fault, "R10 after release",
          {rd_data, 14'h0, rd_valid, fault}, 32'h0);
  endtask

  task automatic t_word_write(input logic [15:0] a, input logic [15:0] d);
    drive(1'b1, 1'b0, a, d);
    check(mem_we == 2'b11, "R4 word write enables", 32'(mem_we), 32'h3);
    check(mem_addr == a[15:1] && !mem_re, "R1 word address", 32'(mem_addr), 32'(a[15:1]));
    check(mem_wdata == d, "R4 word write data", 32'(mem_wdata), 32'(d));
    idle_after_edge();
  endtask

  task automatic t_byte_write(input logic [15:0] a, input logic [7:0] b);
    logic [1:0] exp_we;
    exp_we = a[0] ? 2'b10 : 2'b01;
    drive(1'b1, 1'b1, a, {8'h5A, b});
    check(mem_we == exp_we, "R3 byte lane enable", 32'(mem_we), 32'(exp_we));
    check(mem_wdata == {b, b}, "R3 byte replicated", 32'(mem_wdata), 32'({b, b}));
    idle_after_edge();
    check(!fault, "R6 odd byte write no fault", 32'(fault), 32'h0);
  endtask

  task automatic t_read(input bit byt, input logic [15:0] a, input logic [15:0] exp);
    drive(1'b0, byt, a, 16'h0);
    check(mem_re && mem_addr == a[15:1], "R1 read strobe/address",
          {16'(mem_re), 1'b0, mem_addr}, {16'h1, 1'b0, a[15:1]});
    idle_after_edge();
    check(rd_valid && rd_data == exp, byt ? "R2 byte read" : "R4 word read",
          {15'h0, rd_valid, rd_data}, {16'h1, exp});
    check(!fault, "R6 no fault", 32'(fault), 32'h0);
  endtask

  task automatic t_misalign(input bit wr, input logic [15:0] a);
    drive(wr, 1'b0, a, 16'hFFFF);
    check(mem_we == 2'b00 && !mem_re, "R5 no memory access",
          {29'h0, mem_re, mem_we}, 32'h0);
    idle_after_edge();
    check(fault && !rd_valid, "R5 fault pulse", {30'h0, fault, rd_valid}, 32'h2);
    @(negedge clk);
    check(!fault, "R5 fault one cycle", 32'(fault), 32'h0);
  endtask

  task automatic t_wb(input bit byt, input logic [15:0] old_v, input logic [16:0] r,
                      input logic [15:0] exp_v, input logic [2:0] exp_znc);
    @(negedge clk);
    wb_byte = byt; wb_old = old_v; wb_result = r;
    #1;
    check(wb_value == exp_v, "R7 merge", 32'(wb_value), 32'(exp_v));
    check({flag_z, flag_n, flag_c} == exp_znc, byt ? "R8 byte flags" : "R9 word flags",
          32'({flag_z, flag_n, flag_c}), 32'(exp_znc));
    wb_byte = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ram[i] = 16'h0000;
    t_reset();
    t_word_write(16'h0004, 16'h1234);
    t_byte_write(16'h0005, 8'hCD);
    t_byte_write(16'h0006, 8'h77);
    t_read(1'b0, 16'h0004, 16'hCD34);
    t_read(1'b1, 16'h0004, 16'h0034);
    t_read(1'b1, 16'h0005, 16'h00CD);
    t_read(1'b0, 16'h0006, 16'h0077);
    t_misalign(1'b1, 16'h0005);
    t_read(1'b0, 16'h0004, 16'hCD34);
    t_misalign(1'b0, 16'h0007);
    t_wb(1'b1, 16'hAB00, 17'h01234, 16'hAB34, 3'b000);
    t_wb(1'b1, 16'hAB00, 17'h00100, 16'hAB00, 3'b101);
    t_wb(1'b1, 16'h1111, 17'h00080, 16'h1180, 3'b010);
    t_wb(1'b0, 16'hAB00, 17'h01234, 16'h1234, 3'b000);
    t_wb(1'b0, 16'h0000, 17'h10000, 16'h0000, 3'b101);
    t_wb(1'b0, 16'h0000, 17'h08000, 16'h8000, 3'b010);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule